// File: doc/BRIEF.md
# Synchronizable Clock Divider Bank

A bank of integer clock dividers that all run from one input clock. Each channel divides that clock by its own programmed ratio and drives two identical outputs. An active-low SYNC input stops every participating channel at a known static level. When SYNC is released, all of those channels start again on one common clock edge, so their outputs end up with fixed and known phase relationships.

Every channel has a divide ratio, a phase offset given in input-clock cycles, a start-high bit and an exclude bit. The start-high bit sets the level a channel holds while it is stopped. The phase offset delays that channel's first transition after the common restart edge. An excluded channel takes no part in synchronization: it keeps running through a sync operation and is not realigned. Ratio, phase and start-high values are captured only at a restart, so a running channel never changes its pattern in the middle of a period.

Top module: `clk_div_bank`

## Requirements
- R1: A channel whose exclude bit is 1 ignores sync_n. Its outputs keep toggling during a sync operation, and it captures its configuration only during reset.
- R2: While a sync operation is in progress, both outputs of every non-excluded channel stay at that channel's start-high value (1 = high, 0 = low). This holds from no later than the fourth rising edge after sync_n falls.
- R3: After a restart, the first output transition of a channel comes p rising edges after the common restart edge, where p is its phase offset. An offset that is equal to or greater than the effective ratio is treated as the ratio minus 1.
- R4: sync_n is first synchronized through SYNC_STAGES flops. The restart edge is rising edge LATENCY (default 15), counted from the first rising edge after sync_n goes high. Non-excluded outputs stay static through edge LATENCY-1.
- R5: clk_out_p and clk_out_q of a channel are equal on every cycle.
- R6: The effective ratio N is the programmed ratio clamped to the range 2..MAX_RATIO. Ratios 0 and 1 act as 2. The first transition goes to the inverse of the start-high level. After it, the high level lasts ceil(N/2) cycles and the low level lasts floor(N/2) cycles, and the two keep alternating.
- R7: Ratio, phase and start-high values are taken from the ports on the rising edge just before the restart edge. Changes made while a channel is running have no effect until the next restart.
- R8: While rst is high, every output equals its channel's start-high value. The first rising edge after rst falls acts as the restart edge for every channel, excluded ones included.
- R9: If sync_n falls again before the release count expires, the channels stay static. The latency of R4 is then counted from the final rising edge of sync_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common input clock feeding every divider |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low resynchronization request, may be asynchronous |
| cfg_ratio | input | NUM_CH*RATIO_W | Per-channel divide ratio, channel i in bits [i*RATIO_W +: RATIO_W] |
| cfg_phase | input | NUM_CH*RATIO_W | Per-channel phase offset in input-clock cycles, same packing |
| cfg_start_high | input | NUM_CH | Per-channel static level during sync, 1 = high |
| cfg_exclude | input | NUM_CH | Per-channel exclusion from sync, 1 = excluded |
| clk_out_p | output | NUM_CH | First divided output of each channel |
| clk_out_q | output | NUM_CH | Second divided output of each channel |

## Verification
The bench builds the bank with its default parameters: four channels, MAX_RATIO 32 (so RATIO_W is 6), LATENCY 15 and a two-flop synchronizer. Because RATIO_W is 6, the bench can drive ratios 0, 1 and values above 32, and phase offsets past the ratio, which reaches both clamp rules. Four channels are enough to hold odd, even, minimum and maximum ratios at once, together with an excluded channel. A latency of 15 leaves room to pull sync_n low again halfway through the release count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    SC_IDLE  = 2'd0,
    SC_HOLD  = 2'd1,
    SC_COUNT = 2'd2
  } sync_state_e;

endpackage

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl #(
  parameter int LATENCY     = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_n,
  output logic hold_o
);
  import clkdiv_pkg::*;

  // edges consumed outside the release counter: synchronizer, state entry, channel start
  localparam int REL = LATENCY - SYNC_STAGES - 2;
  localparam int CW  = (REL > 1) ? $clog2(REL) : 1;
  localparam logic [CW-1:0] LAST = CW'(REL - 1);

  logic [SYNC_STAGES-1:0] sreg;
  logic                   sync_s;
  sync_state_e            state;
  logic [CW-1:0]          cnt;

  assign sync_s = sreg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg   <= '1;
      state  <= SC_IDLE;
      cnt    <= '0;
      hold_o <= 1'b0;
    end else begin
      sreg <= {sreg[SYNC_STAGES-2:0], sync_n};
      case (state)
        SC_IDLE: begin
          if (!sync_s) begin
            state  <= SC_HOLD;
            hold_o <= 1'b1;
          end
        end
        SC_HOLD: begin
          if (sync_s) begin
            state <= SC_COUNT;
            cnt   <= '0;
          end
        end
        SC_COUNT: begin
          if (!sync_s) begin
            state <= SC_HOLD;
          end else if (cnt == LAST) begin
            state  <= SC_IDLE;
            hold_o <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state  <= SC_IDLE;
          hold_o <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel #(
  parameter int MAX_RATIO = 32,
  parameter int RATIO_W   = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_i,
  input  logic               excl_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [RATIO_W-1:0] phase_i,
  input  logic               sh_i,
  output logic               out_o
);
  localparam logic [RATIO_W-1:0] R_MIN = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] R_MAX = RATIO_W'(MAX_RATIO);

  logic [RATIO_W-1:0] n_eff, ph_eff, hi_len, lo_len;
  logic [RATIO_W-1:0] hi_q, lo_q, ph_q, cnt;
  logic               sh_q, running, load;

  // clamp ratio and phase once, at capture time
  always_comb begin
    if (ratio_i < R_MIN)      n_eff = R_MIN;
    else if (ratio_i > R_MAX) n_eff = R_MAX;
    else                      n_eff = ratio_i;
    ph_eff = (phase_i >= n_eff) ? (n_eff - 1'b1) : phase_i;
    lo_len = n_eff >> 1;
    hi_len = lo_len + {{(RATIO_W-1){1'b0}}, n_eff[0]};
  end

  assign load = rst || (hold_i && !excl_i);

  always_ff @(posedge clk) begin
    if (load) begin
      hi_q    <= hi_len;
      lo_q    <= lo_len;
      ph_q    <= ph_eff;
      sh_q    <= sh_i;
      out_o   <= sh_i;
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      running <= 1'b1;
      if (ph_q == '0) begin
        out_o <= ~sh_q;
        cnt   <= (sh_q ? lo_q : hi_q) - 1'b1;
      end else begin
        out_o <= sh_q;
        cnt   <= ph_q - 1'b1;
      end
    end else if (cnt == '0) begin
      out_o <= ~out_o;
      cnt   <= (out_o ? lo_q : hi_q) - 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter  int NUM_CH      = 4,
  parameter  int MAX_RATIO   = 32,
  parameter  int LATENCY     = 15,
  parameter  int SYNC_STAGES = 2,
  localparam int RATIO_W     = $clog2(MAX_RATIO + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sync_n,
  input  logic [NUM_CH*RATIO_W-1:0] cfg_ratio,
  input  logic [NUM_CH*RATIO_W-1:0] cfg_phase,
  input  logic [NUM_CH-1:0]         cfg_start_high,
  input  logic [NUM_CH-1:0]         cfg_exclude,
  output logic [NUM_CH-1:0]         clk_out_p,
  output logic [NUM_CH-1:0]         clk_out_q
);

  logic              hold_w;
  logic [NUM_CH-1:0] div_out;

  clkdiv_sync_ctrl #(
    .LATENCY     (LATENCY),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .sync_n (sync_n),
    .hold_o (hold_w)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    clkdiv_channel #(
      .MAX_RATIO (MAX_RATIO),
      .RATIO_W   (RATIO_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .hold_i  (hold_w),
      .excl_i  (cfg_exclude[i]),
      .ratio_i (cfg_ratio[i*RATIO_W +: RATIO_W]),
      .phase_i (cfg_phase[i*RATIO_W +: RATIO_W]),
      .sh_i    (cfg_start_high[i]),
      .out_o   (div_out[i])
    );
  end

  assign clk_out_p = div_out;
  assign clk_out_q = div_out;

endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
  parameter int NUM_CH    = 4,
  parameter int MAX_RATIO = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sync_n,
  input logic              hold,
  input logic [NUM_CH-1:0] cfg_start_high,
  input logic [NUM_CH-1:0] cfg_exclude,
  input logic [NUM_CH-1:0] clk_out_p,
  input logic [NUM_CH-1:0] clk_out_q
);
  localparam int GW = $clog2(MAX_RATIO + 4) + 1;

  p_pair_equal_r5: assert property (@(posedge clk) disable iff (rst)
    clk_out_p == clk_out_q);

  p_hold_after_sync_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> ($past(sync_n, 3) == 1'b0));

  p_release_after_high_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(sync_n, 3) == 1'b1));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [GW-1:0] gap;
    logic          prev;

    always_ff @(posedge clk) begin
      prev <= clk_out_p[i];
      if (rst || !cfg_exclude[i]) gap <= '0;
      else if (clk_out_p[i] != prev) gap <= '0;
      else gap <= gap + 1'b1;
    end

    p_static_level_r2: assert property (@(posedge clk) disable iff (rst)
      (hold && !cfg_exclude[i]) |=> (clk_out_p[i] == $past(cfg_start_high[i])));

    p_excl_running_r1: assert property (@(posedge clk) disable iff (rst)
      cfg_exclude[i] |-> (gap <= GW'(MAX_RATIO + 1)));
  end

endmodule

bind clk_div_bank clk_div_bank_chk #(
  .NUM_CH    (NUM_CH),
  .MAX_RATIO (MAX_RATIO)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .sync_n         (sync_n),
  .hold           (hold_w),
  .cfg_start_high (cfg_start_high),
  .cfg_exclude    (cfg_exclude),
  .clk_out_p      (clk_out_p),
  .clk_out_q      (clk_out_q)
);

// File: tb/clk_div_bank_bench.sv
`timescale 1ns/1ps
module clk_div_bank_bench;
  localparam int NUM_CH  = 4;
  localparam int MAXR    = 32;
  localparam int LAT     = 15;
  localparam int RW      = 6;
  localparam int TRIALS  = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_n = 1'b1;
  logic [NUM_CH*RW-1:0] cfg_ratio = '0;
  logic [NUM_CH*RW-1:0] cfg_phase = '0;
  logic [NUM_CH-1:0]    cfg_start_high = '0;
  logic [NUM_CH-1:0]    cfg_exclude = '0;
  logic [NUM_CH-1:0]    clk_out_p, clk_out_q;

  always #2.5 clk = ~clk;

  clk_div_bank u_clk_div_bank (
    .clk            (clk),
    .rst            (rst),
    .sync_n         (sync_n),
    .cfg_ratio      (cfg_ratio),
    .cfg_phase      (cfg_phase),
    .cfg_start_high (cfg_start_high),
    .cfg_exclude    (cfg_exclude),
    .clk_out_p      (clk_out_p),
    .clk_out_q      (clk_out_q)
  );

  int n_vec = 0;
  int n_bad = 0;
  int r_cfg [NUM_CH];
  int p_cfg [NUM_CH];
  int s_cfg [NUM_CH];
  int x_cfg [NUM_CH];
  int r_act [NUM_CH];
  int p_act [NUM_CH];
  int s_act [NUM_CH];
  int tog   [NUM_CH];
  logic [NUM_CH-1:0] last_out;

  function automatic int model(int ratio, int ph, int sh, int k);
    int n, p, h, l, m;
    n = (ratio < 2) ? 2 : ((ratio > MAXR) ? MAXR : ratio);
    p = (ph >= n) ? n - 1 : ph;
    h = (n + 1) / 2;
    l = n / 2;
    if (k < p) return sh;
    m = (k - p) % n;
    if (sh != 0) return (m < l) ? 0 : 1;
    return (m < h) ? 1 : 0;
  endfunction

  task automatic check(string req, int ch, int got, int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s ch%0d at %0t: got %0d expected %0d", req, ch, $time, got, exp);
    end
  endtask

  task automatic push_cfg();
    for (int i = 0; i < NUM_CH; i++) begin
      cfg_ratio[i*RW +: RW]  = RW'(r_cfg[i]);
      cfg_phase[i*RW +: RW]  = RW'(p_cfg[i]);
      cfg_start_high[i]      = s_cfg[i][0];
      cfg_exclude[i]         = x_cfg[i][0];
    end
  endtask

  task automatic latch_act();
    for (int i = 0; i < NUM_CH; i++) begin
      r_act[i] = r_cfg[i];
      p_act[i] = p_cfg[i];
      s_act[i] = s_cfg[i];
    end
  endtask

  task automatic rand_timing();
    for (int i = 0; i < NUM_CH; i++) begin
      r_cfg[i] = int'($urandom_range(0, 40));
      p_cfg[i] = int'($urandom_range(0, 40));
      s_cfg[i] = int'($urandom_range(0, 1));
    end
  endtask

  // one clock: edge, then sample at the falling edge; R5 on every sample
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_CH; i++) begin
      check("R5", i, int'(clk_out_q[i]), int'(clk_out_p[i]));
      if (clk_out_p[i] != last_out[i]) tog[i]++;
    end
    last_out = clk_out_p;
  endtask

  task automatic check_static(string req);
    for (int i = 0; i < NUM_CH; i++)
      if (x_cfg[i] == 0) check(req, i, int'(clk_out_p[i]), s_cfg[i]);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    join_none
  end

  initial begin
    void'($urandom(32'd20240611));
    last_out = '0;
    // reset with a directed mix of ratios and phases
    r_cfg = '{2, 3, 32, 1};
    p_cfg = '{0, 1, 31, 5};
    s_cfg = '{1, 0, 1, 0};
    x_cfg = '{0, 0, 0, 1};
    push_cfg();
    repeat (3) step();
    for (int i = 0; i < NUM_CH; i++) check("R8", i, int'(clk_out_p[i]), s_cfg[i]);
    latch_act();
    rst = 1'b0;
    for (int e = 1; e <= 40; e++) begin
      step();
      for (int i = 0; i < NUM_CH; i++)
        check("R8", i, int'(clk_out_p[i]), model(r_act[i], p_act[i], s_act[i], e - 1));
    end

    for (int t = 0; t < TRIALS; t++) begin
      if (t == 0) begin
        r_cfg = '{3, 0, 40, 5};
        p_cfg = '{2, 9, 0, 4};
        s_cfg = '{1, 1, 0, 0};
        x_cfg = '{0, 0, 0, 1};
      end else if (t == 1) begin
        r_cfg = '{32, 2, 7, 16};
        p_cfg = '{31, 1, 6, 0};
        s_cfg = '{0, 1, 1, 0};
        x_cfg = '{1, 0, 0, 0};
      end else begin
        rand_timing();
        for (int i = 0; i < NUM_CH; i++) x_cfg[i] = ($urandom_range(0, 3) == 0) ? 1 : 0;
      end
      push_cfg();
      for (int i = 0; i < NUM_CH; i++) tog[i] = 0;

      sync_n = 1'b0;
      repeat (6) step();
      if (t >= 2) begin
        rand_timing();
        push_cfg();
      end
      for (int c = 0; c < 3; c++) begin
        step();
        check_static("R2");
      end
      latch_act();

      if (t % 4 == 3) begin
        sync_n = 1'b1;
        for (int c = 0; c < 6; c++) begin step(); check_static("R9"); end
        sync_n = 1'b0;
        for (int c = 0; c < 4; c++) begin step(); check_static("R9"); end
      end

      sync_n = 1'b1;
      for (int e = 1; e < LAT; e++) begin
        step();
        check_static("R4");
      end
      for (int i = 0; i < NUM_CH; i++)
        if (x_cfg[i] != 0) check("R1", i, (tog[i] >= 1) ? 1 : 0, 1);

      for (int e = LAT; e <= LAT + 80; e++) begin
        step();
        if (e == LAT + 30) begin
          rand_timing();
          push_cfg();
        end
        for (int i = 0; i < NUM_CH; i++)
          if (x_cfg[i] == 0)
            check((t == 0) ? "R6" : ((e > LAT + 30) ? "R7" : "R3"), i,
                  int'(clk_out_p[i]), model(r_act[i], p_act[i], s_act[i], e - LAT));
      end
      for (int i = 0; i < NUM_CH; i++)
        if (x_cfg[i] != 0) check("R1", i, (tog[i] >= 4) ? 1 : 0, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule